// File: doc/BRIEF.md
# Expandable Up/Down Address Sequencer

This block produces the address for one port of a line-buffer memory that has no address bus of its own. A 16-bit counter holds the position. When enabled, it moves one step per clock, either upward or downward. A reload request copies a stored preload word into the counter. This lets a line restart at a fixed origin without any address being driven from outside.

Only the low 13 bits of the count index the 8192-entry array. The three bits above them act as a depth-expansion select. They are compared against a 3-bit device identifier, and the port is treated as active only while the two agree. Several buffers can therefore share one address space, each owning one slice. A port that is out of range still keeps counting, so it re-enters its slice at the right moment.

The preload word and the identifier reach the block as parallel inputs. Whatever loads them serially lies outside this block.

Top module: `addr_sequencer`

## Requirements
- R1: While `rst_n` is low, the count is cleared to 0x0000 at the clock edge, so `countVal` and `memIndex` read zero after reset.
- R2: With `stepEn` high, `reloadReq` low and `countDown` low, the count rises by exactly one at each rising clock edge.
- R3: With `stepEn` high, `reloadReq` low and `countDown` high, the count falls by exactly one at each rising clock edge.
- R4: With `stepEn` and `reloadReq` both low, the count holds its value whatever `countDown` does.
- R5: Counting up from 0xFFFF gives 0x0000.
- R6: Counting down from 0x0000 gives 0xFFFF.
- R7: With `reloadReq` high at a rising edge, the count takes the value of `preloadVal` at that edge.
- R8: When `reloadReq` and `stepEn` are both high, the reload wins and no step is applied on top of it.
- R9: `memIndex` always equals count bits [12:0].
- R10: `portActive` is high exactly when count bits [15:13] equal `deviceId`. It follows the current count and the current `deviceId` without an extra register stage.
- R11: While `portActive` is low, an enabled step still changes the count, just as it does when the port is active.
- R12: `countDown` is sampled on the same edge as the step, so a reversal of direction applies to that very step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stepEn | input | 1 | Step the count at this edge |
| reloadReq | input | 1 | Copy the preload word into the count |
| countDown | input | 1 | 1 = decrement, 0 = increment |
| preloadVal | input | 16 | Preload word used by a reload |
| deviceId | input | 3 | Identifier compared with the count's top bits |
| memIndex | output | 13 | Array index, count bits [12:0] |
| portActive | output | 1 | Count top bits match the identifier |
| countVal | output | 16 | Full count value |

## Verification
The bench uses the default widths: a 16-bit count with a 13-bit index, which leaves a 3-bit select. With these widths, reload makes both wrap points reachable in a single step, and 0x1FFE to 0x2000 is a short walk across a slice boundary. Across that boundary, `portActive` has to switch on while counting carries on. With a 3-bit select, all eight identifier values are legal, so the bench can match the top slice (7) against the wrap at 0xFFFF.

// File: rtl/addrseq_pkg.sv
package addrseq_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic load;   // take the preload word
    logic step;   // move the count by one
    logic down;   // step direction, 1 = decrement
  } seqCtrl_t;

endpackage

// File: rtl/addrseq_ctrl.sv
module addrseq_ctrl
  import addrseq_pkg::*;
(
  input  logic     stepEn,
  input  logic     reloadReq,
  input  logic     countDown,
  output seqCtrl_t ctrl
);

  // Reload has priority: a step is only issued when no reload is pending
  always_comb begin
    ctrl.load = reloadReq;
    ctrl.step = stepEn & ~reloadReq;
    ctrl.down = countDown;
  end

endmodule

// File: rtl/addrseq_dp.sv
module addrseq_dp
  import addrseq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seqCtrl_t               ctrl,
  input  logic [CNT_W-1:0]       preloadVal,
  input  logic [CNT_W-IDX_W-1:0] deviceId,
  output logic [IDX_W-1:0]       memIndex,
  output logic                   portActive,
  output logic [CNT_W-1:0]       countVal
);

  localparam int SEL_W = CNT_W - IDX_W;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countNext;
  logic [SEL_W-1:0] selBits;

  // Modular arithmetic gives both wrap points for free
  always_comb begin
    countNext = countQ;
    if (ctrl.load)
      countNext = preloadVal;
    else if (ctrl.step)
      countNext = ctrl.down ? countQ - 1'b1 : countQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) countQ <= '0;
    else        countQ <= countNext;
  end

  assign selBits    = countQ[CNT_W-1:IDX_W];
  assign memIndex   = countQ[IDX_W-1:0];
  assign portActive = (selBits == deviceId);
  assign countVal   = countQ;

endmodule

// File: rtl/addr_sequencer.sv
module addr_sequencer
  import addrseq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stepEn,
  input  logic                   reloadReq,
  input  logic                   countDown,
  input  logic [CNT_W-1:0]       preloadVal,
  input  logic [CNT_W-IDX_W-1:0] deviceId,
  output logic [IDX_W-1:0]       memIndex,
  output logic                   portActive,
  output logic [CNT_W-1:0]       countVal
);

  seqCtrl_t ctrl;

  addrseq_ctrl u_ctrl (
    .stepEn    (stepEn),
    .reloadReq (reloadReq),
    .countDown (countDown),
    .ctrl      (ctrl)
  );

  addrseq_dp #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .preloadVal (preloadVal),
    .deviceId   (deviceId),
    .memIndex   (memIndex),
    .portActive (portActive),
    .countVal   (countVal)
  );

endmodule

// File: rtl/addr_sequencer_checker.sv
module addr_sequencer_checker #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stepEn,
  input logic                   reloadReq,
  input logic                   countDown,
  input logic [CNT_W-1:0]       preloadVal,
  input logic [CNT_W-IDX_W-1:0] deviceId,
  input logic [IDX_W-1:0]       memIndex,
  input logic                   portActive,
  input logic [CNT_W-1:0]       countVal
);

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stepEn && !reloadReq && !countDown) |=> countVal == CNT_W'($past(countVal) + 1'b1));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepEn && !reloadReq && countDown) |=> countVal == CNT_W'($past(countVal) - 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stepEn && !reloadReq) |=> $stable(countVal));

  // R7 and R8: reload wins over a simultaneous step
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reloadReq |=> countVal == $past(preloadVal));

  p_keep_counting_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!portActive && stepEn && !reloadReq) |=> countVal != $past(countVal));

  p_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    memIndex == countVal[IDX_W-1:0]);

endmodule

bind addr_sequencer addr_sequencer_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/addr_sequencer_test.sv
module addr_sequencer_test;

  localparam int CNT_W = 16;
  localparam int IDX_W = 13;
  localparam int SEL_W = CNT_W - IDX_W;

  typedef struct {
    logic [CNT_W-1:0] count;
    logic             active;
    string            tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stepEn = 1'b0, reloadReq = 1'b0, countDown = 1'b0;
  logic [CNT_W-1:0] preloadVal = '0;
  logic [SEL_W-1:0] deviceId = '0;
  logic [IDX_W-1:0] memIndex;
  logic portActive;
  logic [CNT_W-1:0] countVal;

  int testsRun = 0;
  int testsFailed = 0;
  logic [CNT_W-1:0] model = '0;
  expItem_t expQ[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_sequencer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .stepEn(stepEn), .reloadReq(reloadReq),
    .countDown(countDown), .preloadVal(preloadVal), .deviceId(deviceId),
    .memIndex(memIndex), .portActive(portActive), .countVal(countVal)
  );

  task automatic checkNow(input logic [CNT_W-1:0] expCount, input logic expActive, input string tag);
    testsRun++;
    if (countVal !== expCount || memIndex !== expCount[IDX_W-1:0] || portActive !== expActive) begin
      testsFailed++;
      $display("FAIL %s: count=%h index=%h active=%b expected count=%h index=%h active=%b",
               tag, countVal, memIndex, portActive, expCount, expCount[IDX_W-1:0], expActive);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result
  task automatic drive(input logic en, input logic rl, input logic dn,
                       input logic [CNT_W-1:0] pre, input logic [SEL_W-1:0] id, input string tag);
    expItem_t it;
    @(negedge clk);
    stepEn = en; reloadReq = rl; countDown = dn; preloadVal = pre; deviceId = id;
    if (rl)      model = pre;
    else if (en) model = dn ? model - 1'b1 : model + 1'b1;
    it.count  = model;
    it.active = (model[CNT_W-1:IDX_W] == id);
    it.tag    = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checkNow(it.count, it.active, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkNow(16'h0000, 1'b1, "R1 reset value");
    @(negedge clk);
    rst_n = 1'b1;

    drive(1, 0, 0, 16'h0, 3'd0, "R2 up 1");
    drive(1, 0, 0, 16'h0, 3'd0, "R2 up 2");
    drive(1, 0, 0, 16'h0, 3'd0, "R2 up 3");
    drive(0, 0, 1, 16'h0, 3'd0, "R4 hold dir down");
    drive(0, 0, 0, 16'h0, 3'd0, "R4 hold dir up");
    drive(1, 0, 1, 16'h0, 3'd0, "R3 down");
    drive(1, 0, 0, 16'h0, 3'd0, "R12 reverse to up");
    drive(1, 0, 1, 16'h0, 3'd0, "R12 reverse to down");
    drive(0, 1, 0, 16'h1234, 3'd0, "R7 reload");
    drive(1, 1, 0, 16'hABCD, 3'd0, "R8 reload beats step, R10 inactive");
    drive(0, 0, 0, 16'h0, 3'd5, "R10 id matches top bits");
    drive(0, 1, 0, 16'hFFFF, 3'd7, "R7 reload top");
    drive(1, 0, 0, 16'h0, 3'd7, "R5 wrap up");
    drive(1, 0, 1, 16'h0, 3'd7, "R6 wrap down");
    drive(0, 1, 0, 16'h1FFE, 3'd1, "R10 below slice");
    drive(1, 0, 0, 16'h0, 3'd1, "R11 count while inactive");
    drive(1, 0, 0, 16'h0, 3'd1, "R9 R10 enter slice");
    drive(1, 0, 1, 16'h0, 3'd1, "R11 leave slice");
    drive(0, 0, 0, 16'h0, 3'd1, "R4 idle");

    @(negedge clk);
    stepEn = 0; reloadReq = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule